// File: doc/BRIEF.md
# Mirrored Palette Memory

This block holds a small table of 32 color entries. A clocked write port stores one entry per cycle. A read port returns an entry either in the same cycle or one cycle later, as set by a parameter. Four of the upper-half addresses are backdrop aliases: 0x10, 0x14, 0x18 and 0x1C fold onto 0x00, 0x04, 0x08 and 0x0C. Reads and writes to an alias therefore reach the same cell as its partner.

Each cell keeps six bits, which is the width of a color index, and the two upper bits of the read data are always zero. A grayscale input reduces the returned value to its two brightness bits (bits 5:4) and leaves the stored contents unchanged. A renderer or a host port reads the table through this block. Arbitration between those users and the color output itself belong to other blocks.

Top module: `palette_mirror_mem`

## Requirements
- R1: When `rst_n` is asserted (low), every entry is cleared to zero, and a registered `rd_data` is cleared to zero.
- R2: When `wr_en` is high at a rising edge, bits 5:0 of `wr_data` are stored in the cell selected by `wr_addr`. Bits 7:6 of `rd_data` are always 0.
- R3: An address with bit 4 = 1 and bits 1:0 = 00 (0x10, 0x14, 0x18, 0x1C) selects the same cell as that address with bit 4 cleared. This holds for both writes and reads.
- R4: Every other address in 0x10..0x1F selects its own cell, distinct from any cell in the lower half.
- R5: While `gray_en` is 1, the returned value is the stored value ANDed with 0x30.
- R6: `gray_en` never changes a stored entry. A later read with `gray_en` = 0 returns the full six-bit value.
- R7: In registered mode (the default), `rd_data` after a rising edge holds the entry selected by `rd_addr` and `gray_en` as sampled at that edge. When that edge also writes the same cell, the read returns the contents from before the write.
- R8: When `wr_en` is low at an edge, no entry changes, whatever `wr_addr` and `wr_data` carry.

Port `rst_n` resets asynchronously; its release must be synchronous to `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released synchronously |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 5 | Write address, before alias folding |
| wr_data | input | 8 | Write data; only bits 5:0 are kept |
| rd_addr | input | 5 | Read address, before alias folding |
| gray_en | input | 1 | Grayscale mask on the read data |
| rd_data | output | 8 | Read data |

## Verification
The assertions take the write strobe, the addresses and the grayscale bit as clean, known values at every sampled edge after reset. The write-landing check also assumes that no second write to the same cell arrives in the very next cycle. The stimulus changes every input only on the falling clock edge and holds `wr_en`, `rd_addr` and `gray_en` at defined levels from time zero, so none is ever unknown at a rising edge. Writes are issued one per cycle, and back-to-back writes go to different cells.

// File: rtl/pal_pkg.sv
package pal_pkg;
  typedef enum logic [0:0] {
    RD_COMB = 1'b0,
    RD_REG  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/pal_addr_fold.sv
module pal_addr_fold #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] slot_out
);
  logic is_alias;

  always_comb begin
    is_alias = addr_in[AW-1] && (addr_in[1:0] == 2'b00);
    slot_out = addr_in;
    if (is_alias) begin
      slot_out[AW-1] = 1'b0;
    end
  end
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int AW = 5,
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wslot,
  input  logic [CW-1:0] wdata,
  input  logic [AW-1:0] rslot,
  output logic [CW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][CW-1:0] cell_q;
  logic [DEPTH-1:0][CW-1:0] cell_nxt;

  always_comb begin
    cell_nxt = cell_q;
    if (we) begin
      cell_nxt[wslot] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
    end else if (we) begin
      cell_q <= cell_nxt;
    end
  end

  assign rdata = cell_q[rslot];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (cell_q[$past(wslot)] == $past(wdata))) else $error("write lost"); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> (cell_q == $past(cell_q))) else $error("entry changed without strobe"); // R8
endmodule

// File: rtl/pal_read_stage.sv
module pal_read_stage #(
  parameter int                DW        = 8,
  parameter int                CW        = 6,
  parameter logic [DW-1:0]     GRAY_KEEP = 8'h30,
  parameter pal_pkg::rd_mode_e RD_MODE   = pal_pkg::RD_REG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] raw,
  input  logic          gray_en,
  output logic [DW-1:0] rd_data
);
  localparam int PAD = DW - CW;

  logic [DW-1:0] wide;
  logic [DW-1:0] shaped;

  always_comb begin
    wide   = {{PAD{1'b0}}, raw};
    shaped = gray_en ? (wide & GRAY_KEEP) : wide;
  end

  generate
    if (RD_MODE == pal_pkg::RD_REG) begin : g_reg
      logic [DW-1:0] rd_q;
      logic [DW-1:0] rd_nxt;

      always_comb begin
        rd_nxt = shaped;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rd_q <= '0;
        end else begin
          rd_q <= rd_nxt;
        end
      end

      assign rd_data = rd_q;

      AST_GRAY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        gray_en |=> ((rd_data & ~GRAY_KEEP) == '0)) else $error("gray mask leak"); // R5
    end else begin : g_comb
      assign rd_data = shaped;

      AST_GRAY_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        gray_en |-> ((rd_data & ~GRAY_KEEP) == '0)) else $error("gray mask leak"); // R5
    end
  endgenerate
endmodule

// File: rtl/palette_mirror_mem.sv
module palette_mirror_mem #(
  parameter int                AW        = 5,
  parameter int                DW        = 8,
  parameter int                CW        = 6,
  parameter logic [DW-1:0]     GRAY_KEEP = 8'h30,
  parameter pal_pkg::rd_mode_e RD_MODE   = pal_pkg::RD_REG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          gray_en,
  output logic [DW-1:0] rd_data
);
  logic [AW-1:0] wr_slot;
  logic [AW-1:0] rd_slot;
  logic [CW-1:0] raw;
  logic          unused_hi;

  assign unused_hi = ^wr_data[DW-1:CW];

  pal_addr_fold #(.AW(AW)) u_fold_wr (.addr_in(wr_addr), .slot_out(wr_slot));
  pal_addr_fold #(.AW(AW)) u_fold_rd (.addr_in(rd_addr), .slot_out(rd_slot));

  pal_store #(.AW(AW), .CW(CW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_en),
    .wslot (wr_slot),
    .wdata (wr_data[CW-1:0]),
    .rslot (rd_slot),
    .rdata (raw)
  );

  pal_read_stage #(.DW(DW), .CW(CW), .GRAY_KEEP(GRAY_KEEP), .RD_MODE(RD_MODE)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw     (raw),
    .gray_en (gray_en),
    .rd_data (rd_data)
  );

  AST_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DW-1:CW] == '0) else $error("upper read bits set"); // R2
  AST_ALIAS_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr[AW-1] && rd_addr[1:0] == 2'b00) |->
    (!rd_slot[AW-1] && rd_slot[AW-2:0] == rd_addr[AW-2:0])) else $error("alias not folded"); // R3
  AST_PLAIN_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_addr[AW-1] && wr_addr[1:0] == 2'b00) |-> (wr_slot == wr_addr)) else $error("plain address moved"); // R4
endmodule

// File: tb/palette_mirror_mem_tb.sv
module palette_mirror_mem_tb;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [4:0] wr_addr;
  logic [7:0] wr_data;
  logic [4:0] rd_addr;
  logic       gray_en;
  logic [7:0] rd_data;

  int checks;
  int errors;
  bit done;

  logic [5:0] model [32];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  int         adr_q [$];
  logic       rd_req;
  logic       cap;

  palette_mirror_mem u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .gray_en(gray_en), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int slot_of(int a);
    if (a == 16 || a == 20 || a == 24 || a == 28) return a - 16;
    return a;
  endfunction

  function automatic string tag_of(int a);
    if (a == 16 || a == 20 || a == 24 || a == 28) return "R3";
    if (a >= 16) return "R4";
    return "R2";
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, int a);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%0h actual=%0h expected=%0h", tag, a, act, exp);
    end
  endtask

  // driver: one cycle per call; read result expected after the next rising edge
  task automatic op(bit we, int wa, logic [7:0] wd, bit re, int ra, bit g, string tag);
    logic [7:0] e;
    @(negedge clk);
    wr_en   = we;
    wr_addr = wa[4:0];
    wr_data = wd;
    rd_addr = ra[4:0];
    gray_en = g;
    rd_req  = re;
    if (re) begin
      e = {2'b00, model[slot_of(ra)]};
      if (g) e = e & 8'h30;
      exp_q.push_back(e);
      tag_q.push_back(tag);
      adr_q.push_back(ra);
    end
    if (we) model[slot_of(wa)] = wd[5:0];
  endtask

  task automatic wr(int a, logic [7:0] d);
    op(1'b1, a, d, 1'b0, 0, 1'b0, "");
  endtask

  task automatic rd(int a, bit g, string tag);
    op(1'b0, 0, 8'h00, 1'b1, a, g, tag);
  endtask

  task automatic idle();
    op(1'b0, 0, 8'h00, 1'b0, 0, 1'b0, "");
  endtask

  // monitor
  always @(posedge clk) cap <= rd_req;

  always @(negedge clk) begin
    if (rst_n && cap && exp_q.size() > 0) begin
      check(tag_q.pop_front(), rd_data, exp_q.pop_front(), adr_q.pop_front());
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; gray_en = 1'b0; rd_req = 1'b0; cap = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rd_data, 8'h00, 0);

    // R1: every entry reads zero after reset
    for (int a = 0; a < 32; a++) rd(a, 1'b0, "R1");

    // R2/R4: fill all non-alias addresses with distinct values (bits 7:6 set)
    for (int a = 0; a < 32; a++) begin
      if (slot_of(a) == a) wr(a, 8'hC0 | 8'(a * 2 + 1));
    end
    for (int a = 0; a < 32; a++) rd(a, 1'b0, tag_of(a));

    // R3: write through an alias, read the partner and vice versa
    wr(20, 8'h2A);
    rd(4, 1'b0, "R3");
    rd(20, 1'b0, "R3");
    wr(8, 8'h15);
    rd(24, 1'b0, "R3");
    wr(28, 8'h3F);
    rd(12, 1'b0, "R3");
    wr(16, 8'h07);
    rd(0, 1'b0, "R3");
    rd(17, 1'b0, "R4");

    // R5: grayscale reads
    wr(5, 8'h3F);
    wr(6, 8'h1E);
    rd(5, 1'b1, "R5");
    rd(6, 1'b1, "R5");
    rd(20, 1'b1, "R5");
    // R6: storage unchanged by grayscale
    rd(5, 1'b0, "R6");
    rd(6, 1'b0, "R6");
    rd(4, 1'b0, "R6");

    // R8: strobe low with changing address and data
    for (int a = 0; a < 8; a++) op(1'b0, a, 8'h3C ^ 8'(a), 1'b0, 0, 1'b0, "");
    for (int a = 0; a < 8; a++) rd(a, 1'b0, "R8");

    // R7: read and write of the same cell in one cycle returns old value
    op(1'b1, 9, 8'h21, 1'b1, 9, 1'b0, "R7");
    rd(9, 1'b0, "R7");
    op(1'b1, 28, 8'h11, 1'b1, 12, 1'b0, "R7");
    rd(12, 1'b0, "R7");
    // R7: back-to-back reads with alternating gray
    rd(9, 1'b1, "R7");
    rd(12, 1'b0, "R7");
    rd(31, 1'b1, "R7");

    idle();
    idle();
    idle();
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R7 pending reads actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule